// File: doc/BRIEF.md
# One-Bit Accumulator Execution Core

This core runs a program one instruction at a time on a datapath that is a single bit wide. Each 16-bit instruction word carries a 4-bit operation code in its top nibble. The core also receives one data bit read from the bus. The core holds four one-bit state elements:

- an accumulator,
- a carry flag,
- a store-enable flag,
- a skip flag.

Its outputs are one write-data bit, a write strobe, and three event strobes that go to the sequencing logic around it: jump, return and no-operation. Memory, address formation and the program counter are outside the block.

Each instruction occupies two clock cycles, marked by the `ph2` input. In the first cycle (`ph2` = 0) the next values are formed combinationally. In the second cycle (`ph2` = 1) the strobes are valid, and at the clock edge that ends this cycle the accumulator, carry and store-enable take their new values. The skip flag works on the opposite phase. It loads at the edge that ends the first cycle and then holds through the second cycle. While it is set, the current instruction has no effect of any kind.

The skip flag and the store-enable flag give two levels of conditional execution. The test-zero and return operations skip the single instruction that follows them. Clearing store-enable silences every store but lets all computation continue.

Top module: `bit1_core`

## Requirements
- R1: After reset the accumulator, carry and skip flag are 0, the store-enable flag is 1, and every strobe is low.
- R2: The operation code is `instr[15:12]`. Code 1 loads the bus bit into the accumulator, and code 2 loads its inverse. Bits 11..0 have no effect on the core.
- R3: Codes 8 (XOR), 7 (XNOR), 9 (AND) and A (OR) replace the accumulator with that function of the accumulator and the bus bit. The carry is unchanged.
- R4: Code 6 adds the accumulator, the carry and the bus bit. The sum bit goes to the accumulator and the carry-out goes to the carry.
- R5: Code B sets the accumulator to 1 and clears the carry. Code C clears the accumulator and sets the carry.
- R6: Code 3 raises `wr_en` with `wr_data` equal to the accumulator, and code 4 does the same with its inverse. These outputs appear only while `ph2` = 1, and neither code changes any state.
- R7: Code 5 loads the store-enable flag from the bus bit. While that flag is 0, codes 3 and 4 leave `wr_en` low and everything else behaves normally.
- R8: Code E skips the next instruction when the bus bit is 0. Code F always skips the next instruction and pulses `ret_stb`.
- R9: A skipped instruction raises no strobe and changes no accumulator, carry or store-enable value. It also causes no skip of its own.
- R10: Code D pulses `jmp_stb` and code 0 pulses `nop_stb`. Neither changes the accumulator or the carry.
- R11: State changes only at the edge that ends the `ph2` = 1 cycle. The skip flag changes only at the edge that ends the `ph2` = 0 cycle. All strobes stay low while `ph2` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ph2 | input | 1 | 0 = first (compute) phase, 1 = second (commit) phase |
| instr | input | 16 | Current instruction word |
| bus_in | input | 1 | Data bit read for this instruction |
| wr_data | output | 1 | Bit to write for a store |
| wr_en | output | 1 | Store strobe |
| jmp_stb | output | 1 | Jump strobe |
| ret_stb | output | 1 | Return strobe |
| nop_stb | output | 1 | No-operation strobe |
| acc_o | output | 1 | Accumulator value |
| carry_o | output | 1 | Carry flag |
| oen_o | output | 1 | Store-enable flag |
| skip_o | output | 1 | Skip flag applied to the current instruction |

## Verification
The assertions check the following on every cycle:

- state is frozen during the first phase and throughout any skipped instruction;
- the skip flag holds across the commit phase;
- strobes stay silent in the first phase and under skip, and at most one strobe is high at a time;
- stores are masked while store-enable is 0;
- the forced results of the ONE operation appear after its commit edge.

The arithmetic and logic results need the bench's directed scenarios, which sweep every operand and carry combination. So do the chains in which a skip lands on a skip-causing instruction, and the store-enable flag being toggled through the bus.

// File: rtl/bit1_core.sv
module bit1_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ph2,
  input  logic [15:0] instr,
  input  logic        bus_in,
  output logic        wr_data,
  output logic        wr_en,
  output logic        jmp_stb,
  output logic        ret_stb,
  output logic        nop_stb,
  output logic        acc_o,
  output logic        carry_o,
  output logic        oen_o,
  output logic        skip_o
);
  localparam logic [3:0] OP_NOP  = 4'h0, OP_LD  = 4'h1, OP_LDC = 4'h2, OP_STO = 4'h3;
  localparam logic [3:0] OP_STOC = 4'h4, OP_OEN = 4'h5, OP_ADD = 4'h6, OP_XNR = 4'h7;
  localparam logic [3:0] OP_XOR  = 4'h8, OP_AND = 4'h9, OP_OR  = 4'hA, OP_ONE = 4'hB;
  localparam logic [3:0] OP_TWO  = 4'hC, OP_JMP = 4'hD, OP_SKZ = 4'hE, OP_RET = 4'hF;

  logic [3:0] op;
  logic acc_q, cy_q, oen_q, skip_q, pend_q;
  logic acc_d, cy_d, oen_d, go;

  assign op = instr[15:12];
  assign go = ph2 & ~skip_q;

  always_comb begin
    acc_d = acc_q;
    cy_d  = cy_q;
    oen_d = oen_q;
    case (op)
      OP_LD:   acc_d = bus_in;
      OP_LDC:  acc_d = ~bus_in;
      OP_OEN:  oen_d = bus_in;
      OP_ADD:  {cy_d, acc_d} = {1'b0, acc_q} + {1'b0, cy_q} + {1'b0, bus_in};
      OP_XNR:  acc_d = ~(acc_q ^ bus_in);
      OP_XOR:  acc_d = acc_q ^ bus_in;
      OP_AND:  acc_d = acc_q & bus_in;
      OP_OR:   acc_d = acc_q | bus_in;
      OP_ONE:  begin acc_d = 1'b1; cy_d = 1'b0; end
      OP_TWO:  begin acc_d = 1'b0; cy_d = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      cy_q   <= 1'b0;
      oen_q  <= 1'b1;
      pend_q <= 1'b0;
      skip_q <= 1'b0;
    end else if (ph2) begin
      if (!skip_q) begin
        acc_q <= acc_d;
        cy_q  <= cy_d;
        oen_q <= oen_d;
      end
      pend_q <= ~skip_q & ((op == OP_SKZ & ~bus_in) | (op == OP_RET));
    end else begin
      skip_q <= pend_q;
    end
  end

  assign wr_data = (op == OP_STOC) ? ~acc_q : acc_q;
  assign wr_en   = go & oen_q & ((op == OP_STO) | (op == OP_STOC));
  assign jmp_stb = go & (op == OP_JMP);
  assign ret_stb = go & (op == OP_RET);
  assign nop_stb = go & (op == OP_NOP);
  assign acc_o   = acc_q;
  assign carry_o = cy_q;
  assign oen_o   = oen_q;
  assign skip_o  = skip_q;

  p_skip_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q |-> !(wr_en | jmp_stb | ret_stb | nop_stb));
  p_skip_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2 && skip_q) |=> $stable({acc_q, cy_q, oen_q}));
  p_ph1_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ph2 |=> $stable({acc_q, cy_q, oen_q}));
  p_skip_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ph2 |=> $stable(skip_q));
  p_ph1_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ph2 |-> !(wr_en | jmp_stb | ret_stb | nop_stb));
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, jmp_stb, ret_stb, nop_stb}));
  p_store_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !oen_q |-> !wr_en);
  p_force_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2 && !skip_q && op == OP_ONE) |=> (acc_q && !cy_q));
endmodule

// File: tb/sim_bit1_core.sv
module sim_bit1_core;
  logic clk = 1'b0, rst_n = 1'b0, ph2 = 1'b0, bus_in = 1'b0;
  logic [15:0] instr = 16'h0;
  logic wr_data, wr_en, jmp_stb, ret_stb, nop_stb, acc_o, carry_o, oen_o, skip_o;
  int checks = 0, fails = 0;
  bit m_acc, m_cy, m_oen = 1'b1, m_pend;

  always #2 clk = ~clk;

  bit1_core u0 (.clk(clk), .rst_n(rst_n), .ph2(ph2), .instr(instr), .bus_in(bus_in),
    .wr_data(wr_data), .wr_en(wr_en), .jmp_stb(jmp_stb), .ret_stb(ret_stb),
    .nop_stb(nop_stb), .acc_o(acc_o), .carry_o(carry_o), .oen_o(oen_o), .skip_o(skip_o));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exec(input logic [3:0] op, input bit b, input string tag);
    bit sk;
    logic [3:0] es;
    sk = m_pend;
    @(negedge clk); instr = {op, 12'hA5C}; bus_in = b; ph2 = 1'b0;
    #1 chk({tag, " R11 ph1 strobes"}, {4'h0, wr_en, jmp_stb, ret_stb, nop_stb}, 8'h0);
    @(negedge clk); ph2 = 1'b1;
    #1;
    es = sk ? 4'h0 : {m_oen && (op == 4'h3 || op == 4'h4), op == 4'hD, op == 4'hF, op == 4'h0};
    chk({tag, " R6 R8 R9 R10 strobes"}, {4'h0, wr_en, jmp_stb, ret_stb, nop_stb}, {4'h0, es});
    chk({tag, " R8 skip flag"}, {7'h0, skip_o}, {7'h0, sk});
    if (es[3]) chk({tag, " R6 wr_data"}, {7'h0, wr_data}, {7'h0, (op == 4'h4) ? ~m_acc : m_acc});
    if (!sk) begin
      case (op)
        4'h1: m_acc = b;
        4'h2: m_acc = ~b;
        4'h5: m_oen = b;
        4'h6: begin {m_cy, m_acc} = {1'b0, m_acc} + {1'b0, m_cy} + {1'b0, b}; end
        4'h7: m_acc = ~(m_acc ^ b);
        4'h8: m_acc = m_acc ^ b;
        4'h9: m_acc = m_acc & b;
        4'hA: m_acc = m_acc | b;
        4'hB: begin m_acc = 1'b1; m_cy = 1'b0; end
        4'hC: begin m_acc = 1'b0; m_cy = 1'b1; end
        default: ;
      endcase
    end
    m_pend = !sk && ((op == 4'hE && !b) || op == 4'hF);
    @(posedge clk); #1;
    chk({tag, " R2-state"}, {5'h0, acc_o, carry_o, oen_o}, {5'h0, m_acc, m_cy, m_oen});
  endtask

  task automatic t_reset;
    #1 chk("R1 reset state", {2'h0, acc_o, carry_o, oen_o, skip_o, wr_en, jmp_stb | ret_stb | nop_stb},
           {2'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0});
  endtask

  task automatic t_load;
    exec(4'h1, 1'b1, "R2 LD 1"); exec(4'h1, 1'b0, "R2 LD 0");
    exec(4'h2, 1'b0, "R2 LDC 0"); exec(4'h2, 1'b1, "R2 LDC 1");
  endtask

  task automatic t_logic;
    for (int o = 7; o <= 10; o++)
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++) begin
          exec(4'h1, a[0], "R3 setup");
          exec(o[3:0], b[0], "R3 logic");
        end
  endtask

  task automatic t_add;
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++) begin
          exec(c[0] ? 4'hC : 4'hB, 1'b0, "R5 force");
          exec(4'h1, a[0], "R4 setup");
          exec(4'h6, b[0], "R4 ADD");
        end
  endtask

  task automatic t_store;
    exec(4'h1, 1'b1, "R6 setup");
    exec(4'h3, 1'b0, "R6 STO"); exec(4'h4, 1'b1, "R6 STOC");
    exec(4'h2, 1'b1, "R6 setup0");
    exec(4'h3, 1'b1, "R6 STO 0"); exec(4'h4, 1'b0, "R6 STOC 0");
  endtask

  task automatic t_oen;
    exec(4'h5, 1'b0, "R7 OEN off");
    exec(4'h3, 1'b1, "R7 STO masked"); exec(4'h4, 1'b1, "R7 STOC masked");
    exec(4'hB, 1'b0, "R7 compute on"); exec(4'h8, 1'b1, "R7 compute on");
    exec(4'h5, 1'b1, "R7 OEN on"); exec(4'h3, 1'b0, "R7 STO back");
  endtask

  task automatic t_skip;
    exec(4'h1, 1'b1, "R8 setup");
    exec(4'hE, 1'b1, "R8 SKZ bus1"); exec(4'h2, 1'b1, "R8 not skipped");
    exec(4'hE, 1'b0, "R8 SKZ bus0"); exec(4'h1, 1'b1, "R9 skipped LD");
    exec(4'hF, 1'b0, "R8 RET"); exec(4'h3, 1'b0, "R9 skipped STO");
    exec(4'hE, 1'b0, "R8 SKZ"); exec(4'hF, 1'b0, "R9 skipped RET");
    exec(4'hC, 1'b0, "R9 runs after skipped RET");
    exec(4'hF, 1'b0, "R8 RET"); exec(4'h5, 1'b0, "R9 skipped OEN");
    exec(4'hE, 1'b0, "R8 SKZ"); exec(4'hD, 1'b0, "R9 skipped JMP");
    exec(4'h3, 1'b1, "R9 after skip");
  endtask

  task automatic t_events;
    exec(4'hC, 1'b0, "R10 setup");
    exec(4'hD, 1'b1, "R10 JMP"); exec(4'h0, 1'b1, "R10 NOP");
    exec(4'hB, 1'b0, "R10 setup2");
    exec(4'hD, 1'b0, "R10 JMP"); exec(4'h0, 1'b0, "R10 NOP");
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #5 t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_load(); t_logic(); t_add(); t_store(); t_oen(); t_skip(); t_events();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule